// File: doc/BRIEF.md
# Memory Bank Interface Event Counter

This block is a pair of event counters that sits where a DRAM bank meets the processor it serves. The host uses it to profile memory traffic. Each cycle the DRAM side raises a strobe for each interface event it sees. The events are:

- row ACTIVATEs caused by processor DMA loads and by processor DMA stores;
- 64-bit words read and written by the processor;
- ACTIVATE and REFRESH commands from the host;
- refreshes the interface issues on its own to protect against row-hammer disturbance.

The counters can also count clock cycles.

The host issues a one-cycle command. An enable command carries the mode and two event selectors; it clears both counts and starts counting. A stop command freezes the counts so they can be read. A disable command parks the module so that its counters stop switching.

In narrow mode the block holds two independent counters, each `CNT_W` bits wide. In wide mode the two act as a single counter of twice that width, driven by the first selector. The carry between the halves takes effect in the same cycle, so a read never shows a torn value. The read bus always shows both halves. A format flag tells the host whether to read it as two fields or as one.

Top module: `bank_event_counter`

## Requirements
- R1: After reset the state output is 0 (disabled), the read bus is zero, and strobes change nothing until an enable command is given.
- R2: Command code 1 (enable) clears both counters and latches the mode and both selectors, from any state, and the state output becomes 1 (running). Strobes in the enable cycle are not counted.
- R3: Selector code k for k = 1..7 counts cycles in which `evt_strobe[k-1]` is high. Code 8 counts every running cycle. Codes 0 and 9..15 count nothing.
- R4: In narrow mode (`cfg_wide`=0), the counter chosen by the first selector appears on `rd_data[CNT_W-1:0]` and the counter chosen by the second selector appears on the upper half. Each half adds at most one per cycle and wraps to zero on its own, with no effect on the other half.
- R5: In wide mode (`cfg_wide`=1), `rd_data` is one counter of 2·`CNT_W` bits driven by the first selector, and the second selector is ignored. A low half of all ones moves to zero in the same cycle as the upper half increments.
- R6: Command code 2 (stop) while running moves to state 2 (stopped). The counts then hold whatever the strobes do. A stop in any other state has no effect.
- R7: Command code 3 (disable) moves to state 0 from any state. While disabled the counters hold their values whatever the strobes do.
- R8: No event is counted in a cycle that carries a non-zero command.
- R9: `rd_fmt` shows the mode latched by the last enable. The state output takes only the values 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_op | input | 2 | Host command: 0 idle, 1 enable, 2 stop, 3 disable |
| cfg_wide | input | 1 | Mode taken on enable: 0 two counters, 1 one double-width counter |
| cfg_sel_a | input | SEL_W | Event selector of the first (low) counter, taken on enable |
| cfg_sel_b | input | SEL_W | Event selector of the second (high) counter, taken on enable |
| evt_strobe | input | NUM_EV | One strobe per interface event, bit k-1 for selector code k |
| rd_data | output | 2*CNT_W | Counter readout, high counter in the upper half |
| rd_fmt | output | 1 | Latched mode, telling how to read `rd_data` |
| state_o | output | 2 | 0 disabled, 1 running, 2 stopped |

## Verification
The narrow mode is driven with strobe patterns in which the two selected events are uncorrelated. A swapped selector, or a strobe bit mapped to the wrong code, then shows up as a mismatched half. A long run of the cycle selector wraps the low counter while the high counter watches an unused code under all-ones strobes. This separates independent wrap from a leaking carry. The wide mode is run past the low-half boundary with the second selector set to a busy code, which exposes a late carry or a second selector that still counts. Stop, disable and mid-run commands are issued with every strobe high, so a missed freeze appears at once on the read bus.

// File: rtl/bank_event_counter.sv
module bank_event_counter #(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 7,
  parameter int SEL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ctl_op,
  input  logic                 cfg_wide,
  input  logic [SEL_W-1:0]     cfg_sel_a,
  input  logic [SEL_W-1:0]     cfg_sel_b,
  input  logic [NUM_EV-1:0]    evt_strobe,
  output logic [2*CNT_W-1:0]   rd_data,
  output logic                 rd_fmt,
  output logic [1:0]           state_o
);
  localparam int SRC_N = NUM_EV + 2;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_ENA = 2'd1, OP_STOP = 2'd2, OP_DIS = 2'd3;
  localparam logic [1:0] S_OFF = 2'd0, S_RUN = 2'd1, S_HALT = 2'd2;

  logic [1:0]       st;
  logic             wide_q;
  logic [SEL_W-1:0] sel_a_q, sel_b_q;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic [SRC_N-1:0] src;
  logic             hit_a, hit_b, live, carry;
  logic [CNT_W:0]   lo_sum;

  assign src = {1'b1, evt_strobe, 1'b0};

  always_comb begin
    hit_a = 1'b0;
    hit_b = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (sel_a_q == SEL_W'(i)) hit_a = src[i];
      if (sel_b_q == SEL_W'(i)) hit_b = src[i];
    end
  end

  assign live   = (st == S_RUN) && (ctl_op == OP_IDLE);
  assign lo_sum = {1'b0, lo_q} + {{CNT_W{1'b0}}, hit_a};
  assign carry  = wide_q ? lo_sum[CNT_W] : hit_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_OFF;
      wide_q  <= 1'b0;
      sel_a_q <= '0;
      sel_b_q <= '0;
    end else begin
      case (ctl_op)
        OP_ENA: begin
          st      <= S_RUN;
          wide_q  <= cfg_wide;
          sel_a_q <= cfg_sel_a;
          sel_b_q <= cfg_sel_b;
        end
        OP_STOP: if (st == S_RUN) st <= S_HALT;
        OP_DIS:  st <= S_OFF;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_op == OP_ENA) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (live) begin
      lo_q <= lo_sum[CNT_W-1:0];
      hi_q <= hi_q + {{(CNT_W-1){1'b0}}, carry};
    end
  end

  assign rd_data = {hi_q, lo_q};
  assign rd_fmt  = wide_q;
  assign state_o = st;
endmodule

module bank_event_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         ctl_op,
  input logic [2*CNT_W-1:0] rd_data,
  input logic               rd_fmt,
  input logic [1:0]         state_o
);
  AST_ENA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_op == 2'd1 |=> (rd_data == '0 && state_o == 2'd1)); // R2
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && ctl_op == 2'd0) |=> $stable(rd_data)); // R7
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && ctl_op == 2'd0) |=> $stable(rd_data)); // R6
  AST_CMD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == 2'd2 || ctl_op == 2'd3) |=> $stable(rd_data)); // R8
  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && ctl_op == 2'd0 && rd_fmt)
    |=> ((2*CNT_W)'(rd_data - $past(rd_data)) <= (2*CNT_W)'(1))); // R5
  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && ctl_op == 2'd0 && !rd_fmt)
    |=> (CNT_W'(rd_data[CNT_W-1:0] - $past(rd_data[CNT_W-1:0])) <= CNT_W'(1) &&
         CNT_W'(rd_data[2*CNT_W-1:CNT_W] - $past(rd_data[2*CNT_W-1:CNT_W])) <= CNT_W'(1))); // R4
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3); // R9
endmodule

bind bank_event_counter bank_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .rd_data(rd_data),
  .rd_fmt(rd_fmt), .state_o(state_o)
);

// File: tb/bank_event_counter_tb.sv
module bank_event_counter_tb;
  localparam int W  = 8;
  localparam int NE = 7;
  localparam int EW = 2 * W + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ctl_op = 2'd0;
  logic          cfg_wide = 1'b0;
  logic [3:0]    cfg_sel_a = 4'd0, cfg_sel_b = 4'd0;
  logic [NE-1:0] evt_strobe = '0;
  logic [2*W-1:0] rd_data;
  logic          rd_fmt;
  logic [1:0]    state_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [EW-1:0] exp_q[$];
  string         tag_q[$];

  logic [1:0]   m_st = 2'd0;
  logic         m_wide = 1'b0;
  logic [3:0]   m_sa = 4'd0, m_sb = 4'd0;
  logic [W-1:0] m_lo = '0, m_hi = '0;

  always #5 clk = ~clk;

  bank_event_counter #(.CNT_W(W), .NUM_EV(NE), .SEL_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .cfg_wide(cfg_wide),
    .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b), .evt_strobe(evt_strobe),
    .rd_data(rd_data), .rd_fmt(rd_fmt), .state_o(state_o)
  );

  function automatic logic hit(input logic [3:0] code, input logic [NE-1:0] ev);
    if (code >= 4'd1 && code <= 4'd7) return ev[code-1];
    if (code == 4'd8) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic [1:0] op, input logic wide, input logic [3:0] sa,
                      input logic [3:0] sb, input logic [NE-1:0] ev, input string tag);
    logic [2*W-1:0] full;
    @(negedge clk);
    ctl_op = op; cfg_wide = wide; cfg_sel_a = sa; cfg_sel_b = sb; evt_strobe = ev;
    case (op)
      2'd1: begin m_st = 2'd1; m_wide = wide; m_sa = sa; m_sb = sb; m_lo = '0; m_hi = '0; end
      2'd2: if (m_st == 2'd1) m_st = 2'd2;
      2'd3: m_st = 2'd0;
      default: if (m_st == 2'd1) begin
        if (m_wide) begin
          full = {m_hi, m_lo} + (2*W)'(hit(m_sa, ev));
          {m_hi, m_lo} = full;
        end else begin
          m_lo = m_lo + W'(hit(m_sa, ev));
          m_hi = m_hi + W'(hit(m_sb, ev));
        end
      end
    endcase
    exp_q.push_back({m_st, m_wide, m_hi, m_lo});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [EW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({state_o, rd_fmt, rd_data} !== e) begin
          fails++;
          $display("FAIL %s: got st=%0d fmt=%0d data=%h, expected st=%0d fmt=%0d data=%h",
                   t, state_o, rd_fmt, rd_data, e[EW-1:EW-2], e[2*W], e[2*W-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== '0 || state_o !== 2'd0) begin
      fails++;
      $display("FAIL R1: got st=%0d data=%h, expected st=0 data=0", state_o, rd_data);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R1 idle strobes");
    step(2'd2, 1'b0, 4'd0, 4'd0, '1, "R6 stop while off");

    step(2'd1, 1'b0, 4'd1, 4'd2, '1, "R2 enable narrow");
    for (int i = 0; i < 24; i++)
      step(2'd0, 1'b1, 4'd9, 4'd9, NE'((i * 37 + 5) ^ (i >> 1)), "R4 R3 narrow pattern");
    step(2'd1, 1'b0, 4'd5, 4'd7, '1, "R2 re-enable running");
    for (int i = 0; i < 16; i++)
      step(2'd0, 1'b0, 4'd0, 4'd0, NE'(i * 11 + 3), "R3 host and hammer codes");
    step(2'd1, 1'b0, 4'd3, 4'd6, '0, "R2 enable");
    for (int i = 0; i < 10; i++) step(2'd0, 1'b0, 4'd0, 4'd0, NE'(1 << (i % NE)), "R3 walking strobe");
    step(2'd1, 1'b0, 4'd4, 4'd4, '0, "R2 enable");
    for (int i = 0; i < 8; i++) step(2'd0, 1'b0, 4'd0, 4'd0, NE'(i * 9), "R3 same selector");

    step(2'd1, 1'b0, 4'd8, 4'd12, '0, "R2 enable cycles");
    for (int i = 0; i < 300; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R4 R3 low wraps alone");
    step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R8 idle");
    step(2'd1, 1'b0, 4'd0, 4'd15, '1, "R2 enable none codes");
    for (int i = 0; i < 6; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R3 code 0 and 15 silent");

    step(2'd1, 1'b0, 4'd1, 4'd8, '0, "R2 enable");
    for (int i = 0; i < 5; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R4 run");
    step(2'd2, 1'b0, 4'd0, 4'd0, '1, "R6 R8 stop");
    for (int i = 0; i < 6; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R6 frozen");
    step(2'd2, 1'b0, 4'd0, 4'd0, '1, "R6 stop again");
    step(2'd1, 1'b1, 4'd8, 4'd8, '1, "R2 R9 enable wide from stop");
    for (int i = 0; i < 262; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '0, "R5 carry across halves");
    step(2'd1, 1'b1, 4'd2, 4'd8, '0, "R2 enable wide");
    for (int i = 0; i < 20; i++) step(2'd0, 1'b0, 4'd0, 4'd0, NE'(i * 3), "R5 second selector ignored");
    step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R8 idle");
    step(2'd3, 1'b0, 4'd0, 4'd0, '1, "R7 R8 disable");
    for (int i = 0; i < 6; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R7 disabled holds");
    step(2'd2, 1'b0, 4'd0, 4'd0, '1, "R6 stop while off");
    step(2'd1, 1'b0, 4'd8, 4'd1, '1, "R2 R9 enable narrow after disable");
    for (int i = 0; i < 4; i++) step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R4 run");
    step(2'd3, 1'b0, 4'd0, 4'd0, '1, "R7 disable from running");
    step(2'd0, 1'b0, 4'd0, 4'd0, '1, "R7 hold");

    step(2'd0, 1'b0, 4'd0, 4'd0, '0, "R7 idle");
    ctl_op = 2'd0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule